// File: doc/BRIEF.md
# LCD Line and Mode Sequencer

This block produces the raster timing of a tile-based LCD controller. It runs on the dot clock. It counts dots within a scanline and scanlines within a frame, and it reports a 2-bit display mode. From the current position it also derives three more outputs:

- the access-block flags for sprite attribute memory and video memory;
- a single-cycle vertical-blank interrupt request;
- a mask that keeps the horizontal-blank interrupt from firing near the end of each blanking period.

The pixel pipeline is out of scope, so the pixel-transfer phase always has its nominal length.

When the LCD enable input rises, the sequencer starts a special first line. That line shows no attribute-search phase and is eight dots shorter than a normal line. After it, the sequencer runs normal lines and frames without stopping until the enable input falls. The colour-select input chooses whether video memory is also locked during the attribute-search phase.

Top module: `lcd_timing_seq`

## Requirements
- R1: A normal line lasts 456 dots. The line number goes up by one at the end of each line. After line 153 it returns to 0, so a frame has 154 lines.
- R2: On lines 0 to 143, except the first line after enable, the mode output follows the dot position. The code is 2 (attribute search) for dots 0–79, 3 (pixel transfer) for dots 80–251 and 0 (horizontal blank) for dots 252–455.
- R3: On lines 144 to 153 the mode output is 1 (vertical blank) for every dot.
- R4: `vblank_irq_o` is high for exactly one cycle, on dot 0 of line 144, and is low at all other times.
- R5: The first line after the enable input rises is line 0 and lasts 448 dots. Its mode is 0 for dots 0–79, 3 for dots 80–251 and 0 for dots 252–447. It never reports code 2.
- R6: `hblank_irq_mask_o` is high during dots 0–79 of the first line after enable. On every line from 0 to 143 it is also high during the last 4 dots of the line. At all other times it is low, so it is clear at dot 0 of the next line and throughout vertical blank.
- R7: `oam_wr_block_o` is high exactly when the mode is 2 or 3.
- R8: `vram_block_o` is high whenever the mode is 3. During mode 2 it is high only when `color_mode` is 0.
- R9: While `lcd_en` is low, all outputs are zero: line 0, mode 0 and every flag low. The counters return to dot 0 of line 0, and the next rise of `lcd_en` starts a new first line.
- R10: While `rst` is high and the LCD is disabled, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_en | input | 1 | LCD enable; low stops and clears the sequencer |
| color_mode | input | 1 | 1 selects the colour variant (video memory stays open in mode 2) |
| line_o | output | 8 | Current line number |
| mode_o | output | 2 | Mode code: 0 hblank, 1 vblank, 2 attribute search, 3 transfer |
| oam_wr_block_o | output | 1 | Attribute-memory write lock |
| vram_block_o | output | 1 | Video-memory read and write lock |
| hblank_irq_mask_o | output | 1 | Suppresses the horizontal-blank interrupt |
| vblank_irq_o | output | 1 | Single-cycle vertical-blank request |

## Verification
The assertions check every cycle for relations that always hold between signals:

- the line step and the wrap at the end of each line;
- the single-cycle vertical-blank pulse, and that it coincides with mode 1;
- that the mask is only high inside horizontal blank and is clear at the start of a new line;
- that the first line never reports code 2, and that the colour variant leaves video memory open in mode 2;
- that all outputs are quiet while the LCD is disabled.

Only the bench's scenarios can show the exact dot counts. These are the 448-dot first line, the 80/172/204 split and the 4-dot mask tail. The scenarios also show the full-frame wrap back to a normal line 0, and a restart of the first-line sequence after disable, including a disable pulse of a single cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int DOT_W  = 9;
    localparam int LINE_W = 8;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OAM    = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    typedef struct packed {
        logic              first;
        logic [LINE_W-1:0] line;
        logic [DOT_W-1:0]  dot;
    } lcd_pos_t;

    // Index of the final dot of the current line.
    function automatic logic [DOT_W-1:0] line_end_dot(input logic first,
                                                      input int   line_dots,
                                                      input int   trim);
        return first ? DOT_W'(line_dots - trim - 1) : DOT_W'(line_dots - 1);
    endfunction

endpackage

// File: rtl/lcd_pos_counter.sv
module lcd_pos_counter
    import lcd_seq_pkg::*;
#(
    parameter int LINE_DOTS   = 456,
    parameter int FRAME_LINES = 154,
    parameter int FIRST_TRIM  = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lcd_en,
    output lcd_pos_t pos_o,
    output logic [DOT_W-1:0] end_dot_o
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);

    lcd_pos_t          pos_q, pos_d;
    logic [DOT_W-1:0]  end_dot;

    always_comb begin
        end_dot = line_end_dot(pos_q.first, LINE_DOTS, FIRST_TRIM);
        pos_d   = pos_q;
        if (!lcd_en) begin
            pos_d = '{first: 1'b1, default: '0};
        end else if (pos_q.dot == end_dot) begin
            pos_d.dot   = '0;
            pos_d.first = 1'b0;
            pos_d.line  = (pos_q.line == LAST_LINE) ? '0 : pos_q.line + 1'b1;
        end else begin
            pos_d.dot = pos_q.dot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '{first: 1'b1, default: '0};
        else     pos_q <= pos_d;
    end

    assign pos_o     = pos_q;
    assign end_dot_o = end_dot;

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && pos_q.dot == end_dot && pos_q.line != LAST_LINE)
        |=> (pos_q.line == $past(pos_q.line) + 1'b1 && pos_q.dot == '0)); // R1
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && pos_q.dot == end_dot && pos_q.line == LAST_LINE)
        |=> (pos_q.line == '0 && !pos_q.first)); // R1
    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pos_q.dot <= end_dot); // R5
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lcd_en |=> (pos_q.dot == '0 && pos_q.line == '0 && pos_q.first)); // R9

endmodule

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
    import lcd_seq_pkg::*;
#(
    parameter int OAM_DOTS  = 80,
    parameter int XFER_DOTS = 172,
    parameter int VIS_LINES = 144,
    parameter int MCYC_DOTS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lcd_en,
    input  logic             color_mode,
    input  lcd_pos_t         pos_i,
    input  logic [DOT_W-1:0] end_dot_i,
    output lcd_mode_e        mode_o,
    output logic             oam_blk_o,
    output logic             vram_blk_o,
    output logic             hbl_mask_o
);

    localparam logic [DOT_W-1:0]  OAM_END  = DOT_W'(OAM_DOTS);
    localparam logic [DOT_W-1:0]  HB_START = DOT_W'(OAM_DOTS + XFER_DOTS);
    localparam logic [LINE_W-1:0] VIS_END  = LINE_W'(VIS_LINES);

    logic in_vis, first_span, tail_span;

    assign in_vis     = pos_i.line < VIS_END;
    assign first_span = pos_i.first && pos_i.dot < OAM_END;
    assign tail_span  = pos_i.dot >= HB_START && pos_i.dot > end_dot_i - DOT_W'(MCYC_DOTS);

    always_comb begin
        mode_o = MODE_HBLANK;
        if (lcd_en) begin
            if (!in_vis)                mode_o = MODE_VBLANK;
            else if (pos_i.dot < OAM_END) mode_o = pos_i.first ? MODE_HBLANK : MODE_OAM;
            else if (pos_i.dot < HB_START) mode_o = MODE_XFER;
            else                        mode_o = MODE_HBLANK;
        end
    end

    assign oam_blk_o  = (mode_o == MODE_OAM) || (mode_o == MODE_XFER);
    assign vram_blk_o = (mode_o == MODE_XFER) || (mode_o == MODE_OAM && !color_mode);
    assign hbl_mask_o = lcd_en && in_vis && (first_span || tail_span);

    AST_MASK_IN_HBLANK: assert property (@(posedge clk) disable iff (rst)
        hbl_mask_o |-> mode_o == MODE_HBLANK); // R6
    AST_MASK_CLEAR_NEWLINE: assert property (@(posedge clk) disable iff (rst)
        (pos_i.dot == '0 && !pos_i.first) |-> !hbl_mask_o); // R6
    AST_VBLANK_MODE: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && !in_vis) |-> (mode_o == MODE_VBLANK && !oam_blk_o && !hbl_mask_o)); // R3
    AST_FIRST_NO_OAM: assert property (@(posedge clk) disable iff (rst)
        pos_i.first |-> mode_o != MODE_OAM); // R5
    AST_COLOR_VRAM_OPEN: assert property (@(posedge clk) disable iff (rst)
        (color_mode && mode_o == MODE_OAM) |-> !vram_blk_o); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lcd_en |-> (mode_o == MODE_HBLANK && !oam_blk_o && !vram_blk_o && !hbl_mask_o)); // R9

endmodule

// File: rtl/lcd_vblank_pulse.sv
module lcd_vblank_pulse
    import lcd_seq_pkg::*;
#(
    parameter int VIS_LINES = 144
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lcd_en,
    input  lcd_pos_t  pos_i,
    input  lcd_mode_e mode_i,
    output logic      irq_o
);

    assign irq_o = lcd_en && pos_i.line == LINE_W'(VIS_LINES) && pos_i.dot == '0;

    AST_VBL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R4
    AST_VBL_WITH_MODE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> mode_i == MODE_VBLANK); // R4

endmodule

// File: rtl/lcd_timing_seq.sv
module lcd_timing_seq
    import lcd_seq_pkg::*;
#(
    parameter int LINE_DOTS   = 456,
    parameter int OAM_DOTS    = 80,
    parameter int XFER_DOTS   = 172,
    parameter int VIS_LINES   = 144,
    parameter int FRAME_LINES = 154,
    parameter int FIRST_TRIM  = 8,
    parameter int MCYC_DOTS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lcd_en,
    input  logic              color_mode,
    output logic [LINE_W-1:0] line_o,
    output logic [1:0]        mode_o,
    output logic              oam_wr_block_o,
    output logic              vram_block_o,
    output logic              hblank_irq_mask_o,
    output logic              vblank_irq_o
);

    lcd_pos_t         pos;
    logic [DOT_W-1:0] end_dot;
    lcd_mode_e        mode;

    lcd_pos_counter #(
        .LINE_DOTS  (LINE_DOTS),
        .FRAME_LINES(FRAME_LINES),
        .FIRST_TRIM (FIRST_TRIM)
    ) u_pos (
        .clk      (clk),
        .rst      (rst),
        .lcd_en   (lcd_en),
        .pos_o    (pos),
        .end_dot_o(end_dot)
    );

    lcd_mode_decode #(
        .OAM_DOTS (OAM_DOTS),
        .XFER_DOTS(XFER_DOTS),
        .VIS_LINES(VIS_LINES),
        .MCYC_DOTS(MCYC_DOTS)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .lcd_en    (lcd_en),
        .color_mode(color_mode),
        .pos_i     (pos),
        .end_dot_i (end_dot),
        .mode_o    (mode),
        .oam_blk_o (oam_wr_block_o),
        .vram_blk_o(vram_block_o),
        .hbl_mask_o(hblank_irq_mask_o)
    );

    lcd_vblank_pulse #(
        .VIS_LINES(VIS_LINES)
    ) u_vbl (
        .clk   (clk),
        .rst   (rst),
        .lcd_en(lcd_en),
        .pos_i (pos),
        .mode_i(mode),
        .irq_o (vblank_irq_o)
    );

    assign line_o = lcd_en ? pos.line : '0;
    assign mode_o = mode;

    AST_LINE_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        !lcd_en |-> (line_o == '0 && !vblank_irq_o)); // R9

endmodule

// File: tb/lcd_timing_seq_tb.sv
`timescale 1ns/1ps
module lcd_timing_seq_tb_top;

    typedef struct {
        int    line;
        int    mode;
        int    oam;
        int    vram;
        int    mask;
        int    irq;
        string mtag;
        string ov;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lcd_en = 1'b0;
    logic       color_mode = 1'b0;
    logic [7:0] line_o;
    logic [1:0] mode_o;
    logic       oam_wr_block_o, vram_block_o, hblank_irq_mask_o, vblank_irq_o;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    // Reference position kept by the bench from the requirements.
    int m_dot = 0, m_line = 0;
    bit m_first = 1'b1;

    always #2 clk = ~clk;

    lcd_timing_seq dut_i (
        .clk              (clk),
        .rst              (rst),
        .lcd_en           (lcd_en),
        .color_mode       (color_mode),
        .line_o           (line_o),
        .mode_o           (mode_o),
        .oam_wr_block_o   (oam_wr_block_o),
        .vram_block_o     (vram_block_o),
        .hblank_irq_mask_o(hblank_irq_mask_o),
        .vblank_irq_o     (vblank_irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (line %0d)", req, what, act, exp, line_o);
        end
    endtask

    // Driver: applies inputs, pushes the expected outputs, advances the model.
    task automatic step(input bit r, input bit e, input bit c);
        exp_t x;
        int   len;
        @(negedge clk);
        rst = r; lcd_en = e; color_mode = c;
        len = m_first ? 448 : 456;
        x.ov = r ? "R10" : (!e ? "R9" : "");
        if (!e) begin
            x.line = 0; x.mode = 0; x.oam = 0; x.vram = 0; x.mask = 0; x.irq = 0; x.mtag = "R9";
        end else begin
            x.line = m_line;
            if (m_line >= 144)   begin x.mode = 1; x.mtag = "R3"; end
            else if (m_dot < 80) x.mode = m_first ? 0 : 2;
            else if (m_dot < 252) x.mode = 3;
            else                 x.mode = 0;
            if (m_line < 144) x.mtag = m_first ? "R5" : "R2";
            x.oam  = (x.mode == 2 || x.mode == 3) ? 1 : 0;
            x.vram = (x.mode == 3 || (x.mode == 2 && !c)) ? 1 : 0;
            x.mask = (m_line < 144 && ((m_first && m_dot < 80) || (m_dot >= 252 && m_dot >= len - 4))) ? 1 : 0;
            x.irq  = (m_line == 144 && m_dot == 0) ? 1 : 0;
        end
        sb_q.push_back(x);
        if (r || !e) begin
            m_dot = 0; m_line = 0; m_first = 1'b1;
        end else if (m_dot == len - 1) begin
            m_dot = 0; m_first = 1'b0;
            m_line = (m_line == 153) ? 0 : m_line + 1;
        end else begin
            m_dot++;
        end
    endtask

    task automatic run(input int n, input bit e, input bit c);
        for (int i = 0; i < n; i++) step(1'b0, e, c);
    endtask

    // Monitor: pops one expected item per cycle and compares.
    always @(negedge clk) begin
        exp_t x;
        #1;
        if (sb_q.size() > 0) begin
            x = sb_q.pop_front();
            chk(x.ov != "" ? x.ov : "R1", "line", int'(line_o),            x.line);
            chk(x.ov != "" ? x.ov : x.mtag, "mode", int'(mode_o),          x.mode);
            chk(x.ov != "" ? x.ov : "R7", "oam_block", int'(oam_wr_block_o), x.oam);
            chk(x.ov != "" ? x.ov : "R8", "vram_block", int'(vram_block_o),  x.vram);
            chk(x.ov != "" ? x.ov : "R6", "hbl_mask", int'(hblank_irq_mask_o), x.mask);
            chk(x.ov != "" ? x.ov : "R4", "vbl_irq", int'(vblank_irq_o),    x.irq);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset with LCD disabled
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        run(2, 1'b0, 1'b0);                   // R9 idle
        // R5 first line, R2/R3/R4 full frame, R1 wrap into normal lines 0 and 1
        run(448 + 153 * 456 + 2 * 456, 1'b1, 1'b0);
        run(10, 1'b0, 1'b0);                  // R9 disabled mid-line
        // Colour variant: R8 video memory open during mode 2
        run(448 + 456, 1'b1, 1'b1);
        run(1, 1'b0, 1'b1);                   // R9 single-cycle disable restarts first line
        run(460, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule